// File: doc/BRIEF.md
# Byte-Addressed GPIO Register Window

This block is the runtime register window of a 29-pin general-purpose I/O controller. A host reaches it over a byte-wide request/acknowledge bus with a 4-bit offset. The pins are grouped into four 8-bit ports, where pin n is bit n%8 of port n/8. The last port carries only five pins. Every port has an output latch that the host can read back and a read-only input register. The input register shows the pad levels after a two-flop synchroniser. The first two ports also have an event-enable register and a write-one-to-clear event-status register. Any status bit that is both set and enabled raises the single event output.

Pin direction, drive type and pull-up come from per-pin configuration inputs. A push-pull pin drives its latch value whenever its output enable is set. An open-drain pin only ever pulls low, and it releases the pad when its latch bit is 1.

Host accesses run through a three-state controller. In **IDLE**, a request moves the controller to **XFER** and latches the offset, direction and write data (transition *accept*). XFER always moves to **RESP** (transition *commit*). In that cycle a write updates the addressed register and a read captures the register value. RESP drives the acknowledge for one cycle and returns to IDLE (transition *release*). A request seen in XFER or RESP is dropped.

Top module: `gpio_window`

## Requirements
- R1: After reset, every register in the window reads 0x00, the event output is 0 and no pad is driven high.
- R2: A request sampled in IDLE is acknowledged exactly two clock edges later for one cycle, with read data valid in that cycle. A request sampled in XFER or RESP is ignored and writes nothing.
- R3: Offsets map as follows. For ports 0 and 1, offset 4p+0 is data out, 4p+1 is data in, 4p+2 is event enable and 4p+3 is event status. For ports 2 and 3, offset 8+2(p-2) is data out and 9+2(p-2) is data in.
- R4: Data-out registers read back the last value written. Port 3 data out keeps only bits 4:0, and its bits 7:5 read 0.
- R5: When the push-pull bit of a pin is 1, the pad output equals its data-out bit and the pad output enable equals its configured output enable.
- R6: When the push-pull bit of a pin is 0, the pad output is 0 and the pad output enable is the configured output enable AND NOT the data-out bit.
- R7: Each pad pull-up control equals that pin's pull-up configuration input.
- R8: A data-in read returns the pad levels seen through two synchroniser flops, so a pad change made just before a request does not show in that read. Port 3 bits 7:5 read 0, and writes to data-in offsets are ignored.
- R9: An event-status bit sets on a rising edge of its synchronised input only while its enable bit is 1. Falling edges and disabled pins set nothing.
- R10: Writing 1 to an event-status bit clears it, and writing 0 leaves it unchanged.
- R11: The event output is the OR over ports 0 and 1 of (status AND enable). Clearing an enable bit masks a set status bit without clearing it.
- R12: Offsets 0x0C to 0x0F read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request, sampled in IDLE |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with bus_ack |
| bus_ack | output | 1 | One-cycle access acknowledge |
| pad_in | input | 29 | Raw pad levels |
| cfg_oe | input | 29 | Per-pin output enable |
| cfg_pp | input | 29 | Per-pin push-pull (1) or open-drain (0) |
| cfg_pu | input | 29 | Per-pin pull-up request |
| pad_out | output | 29 | Pad output level |
| pad_oe | output | 29 | Pad output enable |
| pad_pu | output | 29 | Pad pull-up control |
| event_irq | output | 1 | Event output |

## Verification
A vector table writes distinct byte patterns (0xA5, 0x3C, 0x81, 0xFF) to every data-out offset and reads them back. Because each port gets a different pattern, a swapped or misdecoded offset shows up, and the all-ones write into port 3 exposes any storage behind the missing pins. Pad inputs use one 29-bit pattern with a different byte per port. Reading it once before and once after the synchroniser delay separates a correct latency from a missing stage. Event tests mix enabled and disabled bits in the same byte and cover rising and falling edges. They also clear some status bits while leaving others set, and remove an enable while its status stays set, so set logic, clear logic and masking are each checked on their own.

// File: rtl/gpio_window_pkg.sv
package gpio_window_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_XFER = 2'd1,
        S_RESP = 2'd2
    } host_state_e;

    typedef enum logic [2:0] {
        FN_DOUT = 3'd0,
        FN_DIN  = 3'd1,
        FN_EEN  = 3'd2,
        FN_EST  = 3'd3,
        FN_NONE = 3'd4
    } reg_fn_e;

endpackage

// File: rtl/gpio_window_sync.sv
module gpio_window_sync #(
    parameter int WIDTH  = 29,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n)
                chain[s] <= '0;
            else if (s == 0)
                chain[s] <= d_in;
            else
                chain[s] <= chain[(s == 0) ? 0 : s - 1];
        end
    end

    assign d_out = chain[STAGES-1];
endmodule

// File: rtl/gpio_window_host_fsm.sv
module gpio_window_host_fsm
    import gpio_window_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] rd_mux,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              wr_stb,
    output logic [DATA_W-1:0] rdata,
    output logic              ack
);
    host_state_e state, state_nx;
    logic        we_q;

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (req) state_nx = S_XFER;
            S_XFER:  state_nx = S_RESP;
            S_RESP:  state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= S_IDLE;
        else
            state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            we_q    <= 1'b0;
            rdata   <= '0;
        end else begin
            if (state == S_IDLE && req) begin
                addr_q  <= addr;
                wdata_q <= wdata;
                we_q    <= we;
            end
            if (state == S_XFER)
                rdata <= we_q ? '0 : rd_mux;
        end
    end

    always_comb begin
        wr_stb = (state == S_XFER) && we_q;
        ack    = (state == S_RESP);
    end

    p_req_acked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && req) |-> ##2 ack);
    p_ack_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
endmodule

// File: rtl/gpio_window_port.sv
module gpio_window_port
    import gpio_window_pkg::*;
#(
    parameter int  VW        = 8,
    parameter int  DATA_W    = 8,
    parameter bit  HAS_EVENT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_fn_e           fn,
    input  logic [VW-1:0]     wdata,
    input  logic [VW-1:0]     din_sync,
    input  logic [VW-1:0]     cfg_oe,
    input  logic [VW-1:0]     cfg_pp,
    input  logic [VW-1:0]     cfg_pu,
    output logic [DATA_W-1:0] rd_val,
    output logic [VW-1:0]     pad_out,
    output logic [VW-1:0]     pad_oe,
    output logic [VW-1:0]     pad_pu,
    output logic              ev_pend
);
    logic [VW-1:0] dout_q;
    logic [VW-1:0] en_q;
    logic [VW-1:0] st_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            dout_q <= '0;
        else if (wr_en && fn == FN_DOUT)
            dout_q <= wdata;
    end

    if (HAS_EVENT) begin : g_event
        logic [VW-1:0] prev_q;
        logic [VW-1:0] rise;
        logic [VW-1:0] clr;

        always_comb begin
            rise = din_sync & ~prev_q;
            clr  = (wr_en && fn == FN_EST) ? wdata : '0;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q <= '0;
                en_q   <= '0;
                st_q   <= '0;
            end else begin
                prev_q <= din_sync;
                if (wr_en && fn == FN_EEN)
                    en_q <= wdata;
                st_q <= (st_q & ~clr) | (rise & en_q);
            end
        end

        assign ev_pend = |(st_q & en_q);

        p_status_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> ((st_q & ~$past(st_q) & ~$past(en_q)) == '0));
    end else begin : g_no_event
        assign en_q    = '0;
        assign st_q    = '0;
        assign ev_pend = 1'b0;
    end

    always_comb begin
        unique case (fn)
            FN_DOUT: rd_val = DATA_W'(dout_q);
            FN_DIN:  rd_val = DATA_W'(din_sync);
            FN_EEN:  rd_val = DATA_W'(en_q);
            FN_EST:  rd_val = DATA_W'(st_q);
            default: rd_val = '0;
        endcase
    end

    for (genvar b = 0; b < VW; b++) begin : g_pad
        always_comb begin
            if (cfg_pp[b]) begin
                pad_out[b] = dout_q[b];
                pad_oe[b]  = cfg_oe[b];
            end else begin
                pad_out[b] = 1'b0;
                pad_oe[b]  = cfg_oe[b] & ~dout_q[b];
            end
            pad_pu[b] = cfg_pu[b];
        end
    end

    p_od_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((~cfg_pp) & pad_out) == '0);
endmodule

// File: rtl/gpio_window.sv
module gpio_window
    import gpio_window_pkg::*;
#(
    parameter int NUM_PINS     = 29,
    parameter int NUM_EV_PORTS = 2,
    parameter int ADDR_W       = 4,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_req,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [7:0]          bus_wdata,
    output logic [7:0]          bus_rdata,
    output logic                bus_ack,
    input  logic [NUM_PINS-1:0] pad_in,
    input  logic [NUM_PINS-1:0] cfg_oe,
    input  logic [NUM_PINS-1:0] cfg_pp,
    input  logic [NUM_PINS-1:0] cfg_pu,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_pu,
    output logic                event_irq
);
    localparam int PORT_W    = 8;
    localparam int NUM_PORTS = (NUM_PINS + PORT_W - 1) / PORT_W;
    localparam int PSEL_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
    localparam int EV_SPAN   = 4 * NUM_EV_PORTS;
    localparam int MAP_END   = EV_SPAN + 2 * (NUM_PORTS - NUM_EV_PORTS);

    logic [ADDR_W-1:0]   addr_q;
    logic [7:0]          wdata_q;
    logic                wr_stb;
    logic [7:0]          rd_mux;
    logic [NUM_PINS-1:0] din_sync;
    logic                dec_hit;
    logic [PSEL_W-1:0]   dec_port;
    reg_fn_e             dec_fn;
    logic [7:0]          rd_val [NUM_PORTS];
    logic [NUM_PORTS-1:0] ev_pend;

    gpio_window_host_fsm #(.ADDR_W(ADDR_W), .DATA_W(8)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (bus_req),
        .we      (bus_we),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .rd_mux  (rd_mux),
        .addr_q  (addr_q),
        .wdata_q (wdata_q),
        .wr_stb  (wr_stb),
        .rdata   (bus_rdata),
        .ack     (bus_ack)
    );

    gpio_window_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pad_in),
        .d_out (din_sync)
    );

    always_comb begin
        int off;
        off      = int'(addr_q);
        dec_hit  = 1'b0;
        dec_port = '0;
        dec_fn   = FN_NONE;
        if (off < EV_SPAN) begin
            dec_hit  = 1'b1;
            dec_port = PSEL_W'(off / 4);
            dec_fn   = reg_fn_e'(3'(off % 4));
        end else if (off < MAP_END) begin
            dec_hit  = 1'b1;
            dec_port = PSEL_W'(NUM_EV_PORTS + (off - EV_SPAN) / 2);
            dec_fn   = ((off % 2) == 1) ? FN_DIN : FN_DOUT;
        end
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        localparam int VW = (NUM_PINS - p * PORT_W >= PORT_W) ? PORT_W : NUM_PINS - p * PORT_W;
        logic wr_en;
        assign wr_en = wr_stb && dec_hit && (dec_port == PSEL_W'(p));

        gpio_window_port #(
            .VW        (VW),
            .DATA_W    (8),
            .HAS_EVENT (p < NUM_EV_PORTS)
        ) u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en),
            .fn       (dec_fn),
            .wdata    (wdata_q[VW-1:0]),
            .din_sync (din_sync[p*PORT_W +: VW]),
            .cfg_oe   (cfg_oe[p*PORT_W +: VW]),
            .cfg_pp   (cfg_pp[p*PORT_W +: VW]),
            .cfg_pu   (cfg_pu[p*PORT_W +: VW]),
            .rd_val   (rd_val[p]),
            .pad_out  (pad_out[p*PORT_W +: VW]),
            .pad_oe   (pad_oe[p*PORT_W +: VW]),
            .pad_pu   (pad_pu[p*PORT_W +: VW]),
            .ev_pend  (ev_pend[p])
        );
    end

    always_comb begin
        rd_mux = '0;
        for (int p = 0; p < NUM_PORTS; p++)
            if (dec_hit && dec_port == PSEL_W'(p))
                rd_mux = rd_val[p];
    end

    assign event_irq = |ev_pend;

    p_unused_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack && !dec_hit) |-> (bus_rdata == 8'h00));
endmodule

// File: tb/gpio_window_test.sv
module gpio_window_test;
    localparam int NP = 29;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_req = 1'b0;
    logic          bus_we = 1'b0;
    logic [3:0]    bus_addr = '0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic          bus_ack;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] cfg_oe = '0;
    logic [NP-1:0] cfg_pp = '0;
    logic [NP-1:0] cfg_pu = '0;
    logic [NP-1:0] pad_out;
    logic [NP-1:0] pad_oe;
    logic [NP-1:0] pad_pu;
    logic          event_irq;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #5 clk = ~clk;

    gpio_window uut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .pad_in(pad_in), .cfg_oe(cfg_oe), .cfg_pp(cfg_pp),
        .cfg_pu(cfg_pu), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
        .event_irq(event_irq)
    );

    typedef struct packed {
        logic       we;
        logic       chk;
        logic [3:0] addr;
        logic [7:0] wdata;
        logic [7:0] exp;
        logic [7:0] req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 4'h0, 8'hA5, 8'h00, 8'd4},
        '{1'b0, 1'b1, 4'h0, 8'h00, 8'hA5, 8'd4},   // R4 readback port 0
        '{1'b1, 1'b0, 4'h4, 8'h3C, 8'h00, 8'd3},
        '{1'b0, 1'b1, 4'h4, 8'h00, 8'h3C, 8'd3},   // R3 port 1 data out
        '{1'b1, 1'b0, 4'h8, 8'h81, 8'h00, 8'd3},
        '{1'b0, 1'b1, 4'h8, 8'h00, 8'h81, 8'd3},   // R3 port 2 data out
        '{1'b1, 1'b0, 4'hA, 8'hFF, 8'h00, 8'd4},
        '{1'b0, 1'b1, 4'hA, 8'h00, 8'h1F, 8'd4},   // R4 port 3 tail bits
        '{1'b1, 1'b0, 4'h2, 8'h0F, 8'h00, 8'd3},
        '{1'b0, 1'b1, 4'h2, 8'h00, 8'h0F, 8'd3},   // R3 event enable 0
        '{1'b1, 1'b0, 4'h6, 8'hF0, 8'h00, 8'd3},
        '{1'b0, 1'b1, 4'h6, 8'h00, 8'hF0, 8'd3},   // R3 event enable 1
        '{1'b1, 1'b0, 4'h1, 8'hFF, 8'h00, 8'd8},
        '{1'b0, 1'b1, 4'h1, 8'h00, 8'h00, 8'd8},   // R8 data-in write ignored
        '{1'b1, 1'b0, 4'hC, 8'h55, 8'h00, 8'd12},
        '{1'b0, 1'b1, 4'hC, 8'h00, 8'h00, 8'd12},  // R12 unused offset
        '{1'b1, 1'b0, 4'hF, 8'hAA, 8'h00, 8'd12},
        '{1'b0, 1'b1, 4'hF, 8'h00, 8'h00, 8'd12}   // R12 unused offset
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [3:0] a, input logic [7:0] d,
                          output logic [7:0] r);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0;
        @(negedge clk);
        check("R2 ack", 32'(bus_ack), 32'd1);
        r = bus_rdata;
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        logic [7:0] r;
        access(1'b1, a, d, r);
    endtask

    task automatic rd_check(input string req, input logic [3:0] a, input logic [7:0] exp);
        logic [7:0] r;
        access(1'b0, a, 8'h00, r);
        check(req, 32'(r), 32'(exp));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R2 watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 16; a++) rd_check("R1 reset read", 4'(a), 8'h00);
        check("R1 irq", 32'(event_irq), 32'd0);
        check("R1 pad_out", 32'(pad_out), 32'd0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].we) wr(VECS[i].addr, VECS[i].wdata);
            else begin
                access(1'b0, VECS[i].addr, 8'h00, r);
                if (VECS[i].chk) begin
                    n_checks++;
                    if (r !== VECS[i].exp) begin
                        n_fail++;
                        $display("FAIL R%0d vector %0d: actual 0x%0h expected 0x%0h",
                                 VECS[i].req, i, r, VECS[i].exp);
                    end
                end
            end
        end

        // R2 request during XFER is ignored
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 4'h4; bus_wdata = 8'h11;
        @(negedge clk);
        bus_wdata = 8'h22;
        @(negedge clk);
        bus_req = 1'b0;
        check("R2 ack", 32'(bus_ack), 32'd1);
        @(negedge clk);
        check("R2 ack drop", 32'(bus_ack), 32'd0);
        rd_check("R2 ignored request", 4'h4, 8'h11);

        // R5 push-pull drive
        cfg_oe = '1; cfg_pp = '1;
        #1;
        check("R5 pad_out", 32'(pad_out[7:0]), 32'hA5);
        check("R5 pad_oe", 32'(pad_oe[7:0]), 32'hFF);
        // R6 open drain
        cfg_pp = '0;
        #1;
        check("R6 pad_out", 32'(pad_out[7:0]), 32'h00);
        check("R6 pad_oe", 32'(pad_oe[7:0]), 32'h5A);
        cfg_oe = 29'h0000_00F0;
        #1;
        check("R6 pad_oe masked", 32'(pad_oe[7:0]), 32'h50);
        // R7 pull-up
        cfg_pu = 29'h1234_5678;
        #1;
        check("R7 pad_pu", 32'(pad_pu), 32'h1234_5678);
        @(negedge clk);

        // R8 synchroniser latency and input reads
        pad_in = 29'h1FAB_CDEF;
        rd_check("R8 latency", 4'h1, 8'h00);
        repeat (2) @(negedge clk);
        rd_check("R8 din0", 4'h1, 8'hEF);
        rd_check("R8 din1", 4'h5, 8'hCD);
        rd_check("R8 din2", 4'h9, 8'hAB);
        rd_check("R8 din3 tail", 4'hB, 8'h1F);

        // R9 rising edges set only enabled bits
        rd_check("R9 status0", 4'h3, 8'h0F);
        rd_check("R9 status1", 4'h7, 8'hC0);
        check("R11 irq set", 32'(event_irq), 32'd1);
        pad_in = '0;
        repeat (4) @(negedge clk);
        rd_check("R9 falling no set", 4'h3, 8'h0F);

        // R10 write one to clear
        wr(4'h3, 8'h05);
        rd_check("R10 partial clear", 4'h3, 8'h0A);
        wr(4'h3, 8'h0A);
        wr(4'h7, 8'hC0);
        rd_check("R10 clear all", 4'h7, 8'h00);
        check("R11 irq cleared", 32'(event_irq), 32'd0);

        // R11 enable masks status
        pad_in[0] = 1'b1;
        repeat (4) @(negedge clk);
        check("R11 irq on pin 0", 32'(event_irq), 32'd1);
        wr(4'h2, 8'h0E);
        check("R11 irq masked", 32'(event_irq), 32'd0);
        rd_check("R11 status kept", 4'h3, 8'h01);

        // R1 reset mid-run
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd_check("R1 reset dout", 4'h0, 8'h00);
        rd_check("R1 reset status", 4'h3, 8'h00);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule